// File: doc/BRIEF.md
# T1 Transmit Channel Overwrite Logic

This block sits in the transmit path of a T1 framer. Each clock it can accept one outgoing DS0 channel byte. Along with the byte it receives the channel number (1 to 24), the frame number within the superframe, the framing mode (D4 or ESF), the four signaling bits A to D of that channel and the state of the yellow alarm. It can then replace bit 8 with a robbed-bit signaling value. It forces bit 7 to one when the byte would otherwise go out as all zeros, so that ones density is kept. In D4 mode with the yellow alarm active, it forces bit 2 to zero. The processed byte and its channel number come out one clock later.

A 24-bit transparency mask lets channels carry clear data. A host fills the mask through a small write port that holds three byte-wide registers. A channel marked clear gets no signaling and no zero-code stuffing. The D4 yellow alarm overwrite still applies to a clear channel. Two separate control inputs together form a global stuffing override. When both are high, every channel is stuffed, and the mask then only decides which channels receive signaling.

Top module: `t1_chan_overwrite`

## Requirements
- R1: A synchronous active-high reset clears every transparency bit, so all channels are non-clear, and drives `out_valid` low.
- R2: A write with `wr_addr` k (0 to 2) stores `wr_data` bit j as the transparency flag of channel 8k+j+1, where 1 marks the channel clear. A write takes effect from the byte presented in the cycle after the write. A byte presented in the same cycle as the write still sees the old mask.
- R3: With the override inactive and the D4 yellow alarm off, a clear channel's byte is output unchanged.
- R4: In a non-clear channel, bit 8 (`in_byte[0]`) is replaced by a signaling bit, where `in_sig[3]`=A, `in_sig[2]`=B, `in_sig[1]`=C and `in_sig[0]`=D. In D4 mode (`esf_mode`=0), frame 6 takes A and frame 12 takes B. In ESF mode, frames 6, 12, 18 and 24 take A, B, C and D. Bit 8 is left untouched in every other frame.
- R5: If a non-clear channel's byte is all zeros after signaling insertion, bit 7 (`in_byte[1]`) is set, giving 8'h02.
- R6: With `esf_mode`=0 and `yellow_tx`=1, bit 2 (`in_byte[6]`) of every channel is forced to 0, clear channels included. This forcing is applied after stuffing. In ESF mode `yellow_tx` has no effect.
- R7: When `stuff_force_a` and `stuff_force_b` are both 1, zero-code stuffing applies to clear channels as well, while clear channels still receive no signaling. If only one of the two is 1, the override is inactive.
- R8: `out_valid`, `out_byte` and `out_chan` appear exactly one clock after the corresponding input byte, with `out_chan` equal to the input channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mask register write strobe |
| wr_addr | input | 2 | Mask register select (0 to 2) |
| wr_data | input | 8 | Mask register write data |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Channel byte, bit 1 at MSB |
| in_chan | input | 5 | Channel number 1 to 24 |
| in_frame | input | 5 | Frame number within superframe, from 1 |
| esf_mode | input | 1 | 0 = D4, 1 = ESF |
| yellow_tx | input | 1 | Yellow alarm being transmitted |
| in_sig | input | 4 | Signaling bits A,B,C,D (MSB = A) |
| stuff_force_a | input | 1 | Global stuffing override, first enable |
| stuff_force_b | input | 1 | Global stuffing override, second enable |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Processed channel byte |
| out_chan | output | 5 | Channel number of the output byte |

## Verification
All-ones bytes with a zero signaling bit show whether bit 8 is robbed in exactly the right frames for each mode. Zero bytes separate stuffed channels from clear ones, and they also check the mask bit mapping at channels 1, 13 and 24 and their neighbours. Bytes that become zero only after signaling insertion, or that carry a lone bit 2 under D4 yellow, reveal the order of the three overwrites. Driving one override enable at a time, against both together, distinguishes the AND condition. A write issued in the same cycle as a byte shows the one-byte delay of a mask update.

// File: rtl/t1ow_pkg.sv
package t1ow_pkg;
  // Bit positions inside a channel byte (bit 1 = MSB, bit 8 = LSB)
  localparam int unsigned POS_BIT2 = 6;
  localparam int unsigned POS_BIT7 = 1;
  localparam int unsigned POS_BIT8 = 0;
  // Robbed-bit frames are multiples of this stride
  localparam int unsigned ROB_STRIDE = 6;
  localparam int unsigned D4_SIG_COUNT = 2;
  localparam int unsigned ESF_SIG_COUNT = 4;

  typedef enum logic {
    FM_D4  = 1'b0,
    FM_ESF = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/t1ow_mask_regs.sv
module t1ow_mask_regs #(
  parameter int unsigned NUM_CH = 24,
  parameter int unsigned REG_W  = 8,
  localparam int unsigned NUM_REGS = (NUM_CH + REG_W - 1) / REG_W,
  localparam int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] clear_mask
);
  logic [NUM_REGS*REG_W-1:0] flat_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        flat_q[g*REG_W +: REG_W] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        flat_q[g*REG_W +: REG_W] <= wr_data;
      end
    end
  end

  assign clear_mask = flat_q[NUM_CH-1:0];

  // R1: after a reset cycle the mask is empty
  p_mask_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (clear_mask == '0));
endmodule

// File: rtl/t1ow_sig_select.sv
module t1ow_sig_select #(
  parameter int unsigned FRAME_W = 5,
  parameter int unsigned SIG_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] frame,
  input  logic               esf_mode,
  input  logic [SIG_W-1:0]   sig,
  output logic               rob,
  output logic               rob_bit
);
  import t1ow_pkg::*;

  logic [SIG_W-1:0] hit;

  for (genvar g = 0; g < SIG_W; g++) begin : g_slot
    localparam int unsigned SLOT_FRAME = ROB_STRIDE * (g + 1);
    localparam bit IN_D4 = (g < D4_SIG_COUNT);
    localparam bit IN_ESF = (g < ESF_SIG_COUNT);
    always_comb begin
      hit[g] = (frame == FRAME_W'(SLOT_FRAME)) &&
               ((esf_mode == FM_ESF) ? IN_ESF : IN_D4);
    end
  end

  always_comb begin
    rob = |hit;
    rob_bit = 1'b0;
    for (int i = 0; i < SIG_W; i++) begin
      if (hit[i]) rob_bit = sig[SIG_W-1-i];
    end
  end

  // R4: at most one signaling slot is selected
  p_one_slot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  // R4: D4 never robs beyond frame 12
  p_d4_limit_r4: assert property (@(posedge clk) disable iff (rst)
    (esf_mode == FM_D4) && (frame > FRAME_W'(ROB_STRIDE*D4_SIG_COUNT)) |-> !rob);
endmodule

// File: rtl/t1ow_overwrite_core.sv
module t1ow_overwrite_core #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              is_clear,
  input  logic              force_stuff,
  input  logic              rob,
  input  logic              rob_bit,
  input  logic              d4_yellow,
  output logic [BYTE_W-1:0] byte_out
);
  import t1ow_pkg::*;

  logic [BYTE_W-1:0] after_sig;
  logic [BYTE_W-1:0] after_stuff;

  always_comb begin
    after_sig = byte_in;
    if (rob && !is_clear) after_sig[POS_BIT8] = rob_bit;

    after_stuff = after_sig;
    if ((!is_clear || force_stuff) && (after_sig == '0))
      after_stuff[POS_BIT7] = 1'b1;

    byte_out = after_stuff;
    if (d4_yellow) byte_out[POS_BIT2] = 1'b0;
  end
endmodule

// File: rtl/t1_chan_overwrite.sv
module t1_chan_overwrite #(
  parameter int unsigned NUM_CH  = 24,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FRAME_W = 5,
  parameter int unsigned SIG_W   = 4,
  localparam int unsigned NUM_REGS = (NUM_CH + REG_W - 1) / REG_W,
  localparam int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int unsigned CH_W     = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic [CH_W-1:0]    in_chan,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               esf_mode,
  input  logic               yellow_tx,
  input  logic [SIG_W-1:0]   in_sig,
  input  logic               stuff_force_a,
  input  logic               stuff_force_b,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_byte,
  output logic [CH_W-1:0]    out_chan
);
  import t1ow_pkg::*;

  logic [NUM_CH-1:0] clear_mask;
  logic              chan_clear;
  logic              force_stuff;
  logic              d4_yellow;
  logic              rob;
  logic              rob_bit;
  logic [BYTE_W-1:0] core_byte;

  t1ow_mask_regs #(.NUM_CH(NUM_CH), .REG_W(REG_W)) mask_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clear_mask(clear_mask)
  );

  always_comb begin
    chan_clear = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (in_chan == CH_W'(i + 1)) chan_clear = clear_mask[i];
    end
  end

  assign force_stuff = stuff_force_a & stuff_force_b;
  assign d4_yellow   = (esf_mode == FM_D4) & yellow_tx;

  t1ow_sig_select #(.FRAME_W(FRAME_W), .SIG_W(SIG_W)) sig_i (
    .clk(clk), .rst(rst), .frame(in_frame), .esf_mode(esf_mode),
    .sig(in_sig), .rob(rob), .rob_bit(rob_bit)
  );

  t1ow_overwrite_core #(.BYTE_W(BYTE_W)) core_i (
    .byte_in(in_byte), .is_clear(chan_clear), .force_stuff(force_stuff),
    .rob(rob), .rob_bit(rob_bit), .d4_yellow(d4_yellow),
    .byte_out(core_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_byte <= core_byte;
        out_chan <= in_chan;
      end
    end
  end

  // R3: a clear channel passes unchanged without override or D4 yellow
  p_clear_pass_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && chan_clear && !force_stuff && !d4_yellow
    |=> out_byte == $past(in_byte));
  // R5: a non-clear byte never leaves as zero unless D4 yellow removed bit 2
  p_nonclear_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !chan_clear && !d4_yellow |=> out_byte != '0);
  // R6: D4 yellow leaves bit 2 at zero
  p_yellow_bit2_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && d4_yellow |=> !out_byte[POS_BIT2]);
  // R7: with the override every byte is nonzero unless D4 yellow acts
  p_force_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && force_stuff && !d4_yellow |=> out_byte != '0);
  // R8: the output carries the channel of the byte one clock earlier
  p_chan_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && (out_chan == $past(in_chan)));
endmodule

// File: tb/t1_chan_overwrite_tb_top.sv
`timescale 1ns/1ps
module t1_chan_overwrite_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       in_valid;
  logic [7:0] in_byte;
  logic [4:0] in_chan;
  logic [4:0] in_frame;
  logic       esf_mode;
  logic       yellow_tx;
  logic [3:0] in_sig;
  logic       stuff_force_a;
  logic       stuff_force_b;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [4:0] out_chan;

  int checks = 0;
  int errors = 0;
  logic [23:0] tb_mask;

  always #2 clk = ~clk;

  t1_chan_overwrite dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_byte(in_byte), .in_chan(in_chan),
    .in_frame(in_frame), .esf_mode(esf_mode), .yellow_tx(yellow_tx),
    .in_sig(in_sig), .stuff_force_a(stuff_force_a),
    .stuff_force_b(stuff_force_b), .out_valid(out_valid),
    .out_byte(out_byte), .out_chan(out_chan)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference from the requirements, with the bench's own mask copy
  function automatic logic [7:0] model(input logic [7:0] b, input int ch,
      input int fr, input logic esf, input logic yel, input logic [3:0] s,
      input logic fa, input logic fb);
    logic clr;
    logic [7:0] r;
    clr = tb_mask[ch-1];
    r = b;
    if (!clr) begin
      if (fr == 6) r[0] = s[3];
      else if (fr == 12) r[0] = s[2];
      else if (esf && fr == 18) r[0] = s[1];
      else if (esf && fr == 24) r[0] = s[0];
    end
    if ((!clr || (fa && fb)) && r == 8'h00) r[1] = 1'b1;
    if (!esf && yel) r[6] = 1'b0;
    return r;
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    tb_mask[a*8 +: 8] = d;
  endtask

  // Sends one byte (at a negedge), checks the registered result one clock later
  task automatic send(input string req, input logic [7:0] b, input int ch,
      input int fr, input logic esf, input logic yel, input logic [3:0] s,
      input logic fa, input logic fb, input logic [7:0] exp);
    in_valid = 1'b1; in_byte = b; in_chan = 5'(ch); in_frame = 5'(fr);
    esf_mode = esf; yellow_tx = yel; in_sig = s;
    stuff_force_a = fa; stuff_force_b = fb;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_byte, exp);
    check({req, " model"}, exp, model(b, ch, fr, esf, yel, s, fa, fb));
    check("R8 valid", {7'b0, out_valid}, 8'h01);
    check("R8 chan", {3'b0, out_chan}, 8'(ch));
  endtask

  task automatic t_reset;
    check("R1 valid low", {7'b0, out_valid}, 8'h00);
    send("R1 non-clear after reset", 8'h00, 24, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h02);
  endtask

  task automatic t_mapping;
    write_reg(2'd0, 8'h01);
    write_reg(2'd1, 8'h10);
    write_reg(2'd2, 8'h80);
    send("R2 ch1 clear", 8'h00, 1, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00);
    send("R2 ch2 normal", 8'h00, 2, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h02);
    send("R2 ch13 clear", 8'h00, 13, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00);
    send("R2 ch12 normal", 8'h00, 12, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h02);
    send("R2 ch24 clear", 8'h00, 24, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00);
    send("R2 ch23 normal", 8'h00, 23, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h02);
  endtask

  task automatic t_write_timing;
    // write ch2 clear in the same cycle as a ch2 byte: old mask applies
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h03;
    in_valid = 1'b1; in_byte = 8'h00; in_chan = 5'd2; in_frame = 5'd1;
    esf_mode = 1'b1; yellow_tx = 1'b0; in_sig = 4'hF;
    stuff_force_a = 1'b0; stuff_force_b = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; in_valid = 1'b0;
    check("R2 same-cycle write uses old mask", out_byte, 8'h02);
    tb_mask[7:0] = 8'h03;
    send("R2 next byte uses new mask", 8'h00, 2, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_sig_d4;
    send("R4 D4 f6 A", 8'hFF, 3, 6, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b0, 8'hFE);
    send("R4 D4 f12 B", 8'hFF, 3, 12, 1'b0, 1'b0, 4'b1011, 1'b0, 1'b0, 8'hFE);
    send("R4 D4 f5 none", 8'hFF, 3, 5, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 8'hFF);
    send("R4 D4 f18 none", 8'hFF, 3, 18, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 8'hFF);
    send("R4 D4 f6 A=1", 8'hFE, 3, 6, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 8'hFF);
  endtask

  task automatic t_sig_esf;
    send("R4 ESF f18 C", 8'hFF, 4, 18, 1'b1, 1'b0, 4'b1101, 1'b0, 1'b0, 8'hFE);
    send("R4 ESF f24 D", 8'hFF, 4, 24, 1'b1, 1'b0, 4'b1110, 1'b0, 1'b0, 8'hFE);
    send("R4 ESF f12 B", 8'h00, 4, 12, 1'b1, 1'b0, 4'b0100, 1'b0, 1'b0, 8'h01);
    send("R4 ESF f7 none", 8'hFF, 4, 7, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'hFF);
    send("R5 zero after signaling", 8'h01, 4, 6, 1'b1, 1'b0, 4'b0111, 1'b0, 1'b0, 8'h02);
    send("R5 nonzero not stuffed", 8'h80, 4, 1, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'h80);
    send("R3 clear no signaling", 8'hFF, 1, 6, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 8'hFF);
    send("R3 clear zero kept", 8'h00, 1, 24, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_yellow;
    send("R6 D4 yellow clear ch", 8'hFF, 1, 1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 8'hBF);
    send("R6 D4 yellow after stuff", 8'h40, 5, 1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, 8'h00);
    send("R6 ESF yellow ignored", 8'hFF, 1, 1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, 8'hFF);
    send("R6 D4 yellow off", 8'hFF, 5, 1, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 8'hFF);
  endtask

  task automatic t_override;
    send("R7 both set stuffs clear", 8'h00, 1, 1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 8'h02);
    send("R7 both set no signaling", 8'hFF, 1, 6, 1'b1, 1'b0, 4'b0000, 1'b1, 1'b1, 8'hFF);
    send("R7 only a", 8'h00, 1, 1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 8'h00);
    send("R7 only b", 8'h00, 24, 1, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 8'h00);
    send("R7 override normal ch", 8'h00, 6, 1, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 8'h02);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    in_valid = 1'b0; in_byte = '0; in_chan = 5'd1; in_frame = 5'd1;
    esf_mode = 1'b0; yellow_tx = 1'b0; in_sig = '0;
    stuff_force_a = 1'b0; stuff_force_b = 1'b0;
    tb_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mapping();
    t_write_timing();
    t_sig_d4();
    t_sig_esf();
    t_yellow();
    t_override();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule